// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block sequences the fetch address of a pipelined 32-bit processor in which every jump and branch is followed by exactly one delay-slot instruction. That instruction always executes. The fetch side is a valid/ready stream. The sequencer presents `fetch_pc` with `fetch_valid`, and the address advances only on a cycle where both `fetch_valid` and `fetch_ready` are high. While `fetch_ready` is low, the address and any pending branch target are held. Exception entry and return from exception redirect the fetch address regardless of `fetch_ready`.

Decode reports each jump or branch through `br_valid`, together with the following:
- its own address;
- whether it is taken;
- its target;
- whether the target came from a register;
- whether it writes a return link.

Decode raises `br_valid` while the sequencer presents that branch's delay slot (`br_pc + 4`). A taken target is applied at the first accepted fetch of that delay slot. If that fetch happens in the same cycle as the report, the target is applied at once.

The block keeps a short history of recent branch addresses. When an exception hits an instruction that sits in a recorded delay slot, the exception PC is backed up to the branch and the slot flag is set. A later return then re-executes both the branch and its delay slot.

A jump whose delay slot is itself a jump is not detected, and behaviour in that case is unspecified.

Top module: `dslot_pc_seq`

## Requirements
- R1: While reset is asserted, `fetch_pc` equals RESET_VEC, `fetch_valid`, `epc_in_slot` and `link_we` are 0, `epc` is 0, and no branch target is pending. `fetch_valid` rises at the first clock edge after reset is released.
- R2: On an accepted fetch (`fetch_valid && fetch_ready`) with no redirect, `fetch_pc` advances by 4 at the next edge. Without acceptance, `fetch_pc` holds.
- R3: For a taken branch reported on a cycle with an accepted fetch, `fetch_pc` becomes the target at the next edge. For a taken branch reported without acceptance, the target is held pending, and `fetch_pc` becomes the target at the edge after the next accepted fetch.
- R4: A branch reported with `br_taken` low leaves sequential fetch unchanged.
- R5: For a target with `br_by_reg` low, bits [1:0] of `br_target` are forced to zero. For a target with `br_by_reg` high, the target is used unmodified.
- R6: `fetch_addr_err` is high exactly when `fetch_valid` is high and `fetch_pc[1:0]` is nonzero. The error therefore appears when the misaligned target is presented, not when the jump is reported.
- R7: `exc_req` sets `fetch_pc` to EXC_VEC at the next edge. It takes priority over `eret`, over branches and over a pending target, and it clears the pending target and the branch history.
- R8: On `exc_req`, if `exc_pc` is not the delay slot of a recorded branch, `epc` becomes `exc_pc` and `epc_in_slot` becomes 0.
- R9: On `exc_req`, if `exc_pc` equals the address plus 4 of a branch among the last DS_DEPTH reported since the last flush, `epc` becomes that branch's address and `epc_in_slot` becomes 1. If several branches match, the most recent one is used.
- R10: `eret` without `exc_req` sets `fetch_pc` to `epc` at the next edge and clears the pending target and the branch history.
- R11: A reported branch with `br_link` high, in a cycle without `exc_req` or `eret`, gives one cycle of `link_we` at the next edge. In that cycle `link_data` is `br_pc + 8` and `link_idx` is 31.
- R12: `epc` and `epc_in_slot` change only on `exc_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | output | 32 | Address offered to instruction fetch |
| fetch_valid | output | 1 | Fetch address is valid |
| fetch_ready | input | 1 | Fetch accepts the address this cycle |
| br_valid | input | 1 | Decode reports a jump or branch |
| br_taken | input | 1 | Reported branch is taken |
| br_by_reg | input | 1 | Target comes from a register |
| br_link | input | 1 | Branch stores a return link |
| br_pc | input | 32 | Address of the reported branch |
| br_target | input | 32 | Branch target address |
| exc_req | input | 1 | Exception or interrupt taken |
| exc_pc | input | 32 | Address of the interrupted instruction |
| eret | input | 1 | Return from exception |
| epc | output | 32 | Restart address |
| epc_in_slot | output | 1 | Restart address was backed up to a branch |
| fetch_addr_err | output | 1 | Presented fetch address is misaligned |
| link_we | output | 1 | Link register write strobe |
| link_idx | output | 5 | Link register number |
| link_data | output | 32 | Return link value |

## Verification
`fetch_pc`, `fetch_valid`, `epc`, `epc_in_slot`, `link_we` and `link_data` are registers, so each result of a stimulus is due at the first rising edge after that stimulus is applied. `fetch_addr_err` is decoded from the registered fetch address, so it follows `fetch_pc` in the same cycle. A pending target is the one result that needs two edges: it appears only after a later accepted fetch.

The bench drives inputs on the falling edge and advances its own model by one step. It compares every output at the following falling edge, which is one rising edge later. A deferred target is therefore checked on the cycle after its releasing handshake, and never earlier.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int ADDR_W = 32;
  localparam int INSN_BYTES = 4;
  localparam int REG_IDX_W = 5;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic  valid;
    logic  taken;
    logic  by_reg;
    logic  link;
    addr_t pc;
    addr_t target;
  } br_req_t;

  function automatic addr_t word_align(input addr_t a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction

  function automatic addr_t next_insn(input addr_t a);
    return a + addr_t'(INSN_BYTES);
  endfunction
endpackage

// File: rtl/pcseq_slot_track.sv
module pcseq_slot_track
  import pcseq_pkg::*;
#(
  parameter int DS_DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  addr_t push_pc,
  input  logic  flush,
  input  logic  exc_req,
  input  addr_t exc_pc,
  output addr_t epc,
  output logic  in_slot
);
  logic [DS_DEPTH-1:0] ent_v;
  addr_t               ent_pc [DS_DEPTH];
  logic [DS_DEPTH-1:0] match;
  logic                hit;
  addr_t               hit_pc;

  for (genvar g = 0; g < DS_DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_v[g]  <= 1'b0;
        ent_pc[g] <= '0;
      end else if (flush) begin
        ent_v[g]  <= 1'b0;
      end else if (push) begin
        if (g == 0) begin
          ent_v[g]  <= 1'b1;
          ent_pc[g] <= push_pc;
        end else begin
          ent_v[g]  <= ent_v[g-1];
          ent_pc[g] <= ent_pc[g-1];
        end
      end
    end
    assign match[g] = ent_v[g] && (next_insn(ent_pc[g]) == exc_pc);
  end

  always_comb begin
    hit    = 1'b0;
    hit_pc = '0;
    for (int i = DS_DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit    = 1'b1;
        hit_pc = ent_pc[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc     <= '0;
      in_slot <= 1'b0;
    end else if (exc_req) begin
      epc     <= hit ? hit_pc : exc_pc;
      in_slot <= hit;
    end
  end

  assert_slot_backup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && hit) |=> (in_slot && next_insn(epc) == $past(exc_pc)));

  assert_plain_epc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !hit) |=> (!in_slot && epc == $past(exc_pc)));

  assert_epc_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |=> ($stable(epc) && $stable(in_slot)));
endmodule

// File: rtl/pcseq_fetch.sv
module pcseq_fetch
  import pcseq_pkg::*;
#(
  parameter addr_t RESET_VEC = 32'h0000_1000,
  parameter addr_t EXC_VEC   = 32'h0000_0080
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ready,
  input  br_req_t br,
  input  logic    exc_req,
  input  logic    eret,
  input  addr_t   epc,
  output addr_t   pc,
  output logic    valid,
  output logic    addr_err
);
  logic  pend_v;
  addr_t pend_tgt;
  logic  hs;
  logic  take;
  addr_t tgt;
  addr_t seq_next;

  assign hs       = valid && ready;
  assign take     = br.valid && br.taken;
  assign tgt      = br.by_reg ? br.target : word_align(br.target);
  assign seq_next = pend_v ? pend_tgt : next_insn(pc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= RESET_VEC;
      valid    <= 1'b0;
      pend_v   <= 1'b0;
      pend_tgt <= '0;
    end else begin
      valid <= 1'b1;
      if (exc_req) begin
        pc     <= EXC_VEC;
        pend_v <= 1'b0;
      end else if (eret) begin
        pc     <= epc;
        pend_v <= 1'b0;
      end else if (hs) begin
        pc     <= take ? tgt : seq_next;
        pend_v <= 1'b0;
      end else if (take) begin
        pend_v   <= 1'b1;
        pend_tgt <= tgt;
      end
    end
  end

  assign addr_err = valid && (pc[1:0] != 2'b00);

  assert_exc_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> (pc == EXC_VEC));

  assert_eret_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !exc_req) |=> (pc == $past(epc)));

  assert_backpressure_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !exc_req && !eret) |=> $stable(pc));

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !exc_req && !eret && !take && !pend_v) |=> (pc == $past(pc) + 32'd4));
endmodule

// File: rtl/pcseq_link.sv
module pcseq_link
  import pcseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  br_req_t br,
  input  logic    suppress,
  output logic    we,
  output addr_t   data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we   <= 1'b0;
      data <= '0;
    end else begin
      we <= br.valid && br.link && !suppress;
      if (br.valid && br.link && !suppress) data <= next_insn(next_insn(br.pc));
    end
  end

  assert_link_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (br.valid && br.link && !suppress) |=> (we && data == $past(br.pc) + 32'd8));

  assert_link_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!br.valid || suppress) |=> !we);
endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
  import pcseq_pkg::*;
#(
  parameter int          DS_DEPTH  = 4,
  parameter logic [31:0] RESET_VEC = 32'h0000_1000,
  parameter logic [31:0] EXC_VEC   = 32'h0000_0080,
  parameter int          LINK_REG  = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] fetch_pc,
  output logic        fetch_valid,
  input  logic        fetch_ready,
  input  logic        br_valid,
  input  logic        br_taken,
  input  logic        br_by_reg,
  input  logic        br_link,
  input  logic [31:0] br_pc,
  input  logic [31:0] br_target,
  input  logic        exc_req,
  input  logic [31:0] exc_pc,
  input  logic        eret,
  output logic [31:0] epc,
  output logic        epc_in_slot,
  output logic        fetch_addr_err,
  output logic        link_we,
  output logic [4:0]  link_idx,
  output logic [31:0] link_data
);
  br_req_t br;
  logic    flush;

  assign br    = '{valid: br_valid, taken: br_taken, by_reg: br_by_reg,
                   link: br_link, pc: br_pc, target: br_target};
  assign flush = exc_req || eret;

  pcseq_fetch #(
    .RESET_VEC (RESET_VEC),
    .EXC_VEC   (EXC_VEC)
  ) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (fetch_ready),
    .br       (br),
    .exc_req  (exc_req),
    .eret     (eret),
    .epc      (epc),
    .pc       (fetch_pc),
    .valid    (fetch_valid),
    .addr_err (fetch_addr_err)
  );

  pcseq_slot_track #(
    .DS_DEPTH (DS_DEPTH)
  ) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (br_valid),
    .push_pc (br_pc),
    .flush   (flush),
    .exc_req (exc_req),
    .exc_pc  (exc_pc),
    .epc     (epc),
    .in_slot (epc_in_slot)
  );

  pcseq_link u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .br       (br),
    .suppress (flush),
    .we       (link_we),
    .data     (link_data)
  );

  assign link_idx = REG_IDX_W'(LINK_REG);

  assert_valid_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fetch_valid);
endmodule

// File: tb/dslot_pc_seq_bench.sv
`timescale 1ns/1ps
module dslot_pc_seq_bench;
  localparam int          DEPTH = 4;
  localparam logic [31:0] RV    = 32'h0000_1000;
  localparam logic [31:0] EV    = 32'h0000_0080;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        fetch_ready, br_valid, br_taken, br_by_reg, br_link, exc_req, eret;
  logic [31:0] br_pc, br_target, exc_pc;
  logic [31:0] fetch_pc, epc, link_data;
  logic        fetch_valid, epc_in_slot, fetch_addr_err, link_we;
  logic [4:0]  link_idx;

  dslot_pc_seq #(.DS_DEPTH(DEPTH), .RESET_VEC(RV), .EXC_VEC(EV), .LINK_REG(31))
  u_dslot_pc_seq (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .br_valid(br_valid), .br_taken(br_taken),
    .br_by_reg(br_by_reg), .br_link(br_link), .br_pc(br_pc), .br_target(br_target),
    .exc_req(exc_req), .exc_pc(exc_pc), .eret(eret), .epc(epc),
    .epc_in_slot(epc_in_slot), .fetch_addr_err(fetch_addr_err), .link_we(link_we),
    .link_idx(link_idx), .link_data(link_data));

  int tests = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_pc, m_ptgt, m_epc, m_ldata;
  logic        m_valid, m_pend, m_bd, m_lwe;
  logic [31:0] m_tpc [DEPTH];
  bit          m_tv  [DEPTH];
  string       pc_tag, epc_tag;
  bit          ds_open;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tgt_of(input bit by_reg, input logic [31:0] t);
    return by_reg ? t : {t[31:2], 2'b00};
  endfunction

  function automatic bit find_slot(input logic [31:0] xpc, output logic [31:0] bpc);
    bpc = 32'h0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (m_tv[i] && m_tpc[i] + 32'd4 == xpc) begin
        bpc = m_tpc[i];
        find_slot = 1'b1;
      end
    if (bpc == 32'h0 && !(m_tv[0] && m_tpc[0] + 32'd4 == xpc)) begin
      find_slot = 1'b0;
      for (int i = 0; i < DEPTH; i++)
        if (m_tv[i] && m_tpc[i] + 32'd4 == xpc) find_slot = 1'b1;
    end
  endfunction

  task automatic model_step(input bit rdy, bv, bt, breg, blnk, input logic [31:0] bpc, btgt,
                            input bit ex, input logic [31:0] xpc, input bit er);
    bit hs = m_valid && rdy;
    logic [31:0] t = tgt_of(breg, btgt);
    logic [31:0] spc;
    bit hit;
    pc_tag = hs ? "R2" : "R2";
    epc_tag = "R12";
    m_lwe = 1'b0;
    if (ex) begin
      hit = find_slot(xpc, spc);
      m_epc = hit ? spc : xpc;
      m_bd = hit;
      epc_tag = hit ? "R9" : "R8";
      m_pc = EV; m_pend = 0; pc_tag = "R7";
      for (int i = 0; i < DEPTH; i++) m_tv[i] = 0;
    end else if (er) begin
      m_pc = m_epc; m_pend = 0; pc_tag = "R10";
      for (int i = 0; i < DEPTH; i++) m_tv[i] = 0;
    end else begin
      if (bv && blnk) begin m_lwe = 1'b1; m_ldata = bpc + 32'd8; end
      if (bv) begin
        for (int i = DEPTH - 1; i > 0; i--) begin m_tv[i] = m_tv[i-1]; m_tpc[i] = m_tpc[i-1]; end
        m_tv[0] = 1; m_tpc[0] = bpc;
        if (!bt) pc_tag = "R4";
      end
      if (hs) begin
        if (bv && bt) begin m_pc = t; pc_tag = (!breg && btgt[1:0] != 0) ? "R5" : "R3"; end
        else if (m_pend) begin m_pc = m_ptgt; pc_tag = "R3"; end
        else m_pc = m_pc + 32'd4;
        m_pend = 0;
      end else if (bv && bt) begin
        m_pend = 1; m_ptgt = t; pc_tag = "R3";
      end
    end
    m_valid = 1'b1;
  endtask

  task automatic check_all();
    chk(pc_tag, "fetch_pc", fetch_pc, m_pc);
    chk("R1", "fetch_valid", {31'b0, fetch_valid}, {31'b0, m_valid});
    chk(epc_tag, "epc", epc, m_epc);
    chk(epc_tag, "epc_in_slot", {31'b0, epc_in_slot}, {31'b0, m_bd});
    chk("R6", "fetch_addr_err", {31'b0, fetch_addr_err}, {31'b0, m_valid && m_pc[1:0] != 2'b00});
    chk("R11", "link_we", {31'b0, link_we}, {31'b0, m_lwe});
    if (m_lwe) begin
      chk("R11", "link_data", link_data, m_ldata);
      chk("R11", "link_idx", {27'b0, link_idx}, 32'd31);
    end
  endtask

  task automatic step(input bit rdy, bv, bt, breg, blnk, input logic [31:0] bpc, btgt,
                      input bit ex, input logic [31:0] xpc, input bit er);
    fetch_ready = rdy; br_valid = bv; br_taken = bt; br_by_reg = breg; br_link = blnk;
    br_pc = bpc; br_target = btgt; exc_req = ex; exc_pc = xpc; eret = er;
    model_step(rdy, bv, bt, breg, blnk, bpc, btgt, ex, xpc, er);
    @(negedge clk);
    check_all();
  endtask

  task automatic idle(input bit rdy);
    step(rdy, 0, 0, 0, 0, 32'h0, 32'h0, 0, 32'h0, 0);
  endtask

  task automatic branch(input bit rdy, bt, breg, blnk, input logic [31:0] btgt);
    step(rdy, 1, bt, breg, blnk, m_pc - 32'd4, btgt, 0, 32'h0, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] bp;
    void'($urandom(32'd20240611));
    fetch_ready = 0; br_valid = 0; br_taken = 0; br_by_reg = 0; br_link = 0;
    br_pc = 0; br_target = 0; exc_req = 0; exc_pc = 0; eret = 0;
    m_pc = RV; m_valid = 0; m_pend = 0; m_ptgt = 0; m_epc = 0; m_bd = 0; m_lwe = 0; m_ldata = 0;
    for (int i = 0; i < DEPTH; i++) begin m_tv[i] = 0; m_tpc[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: state held during reset
    chk("R1", "reset fetch_pc", fetch_pc, RV);
    chk("R1", "reset fetch_valid", {31'b0, fetch_valid}, 32'd0);
    chk("R1", "reset epc", epc, 32'd0);
    chk("R1", "reset epc_in_slot", {31'b0, epc_in_slot}, 32'd0);
    chk("R1", "reset link_we", {31'b0, link_we}, 32'd0);
    rst_n = 1'b1;
    idle(1);
    // R2: sequential advance and hold under back-pressure
    idle(1); idle(1); idle(0); idle(0); idle(1);
    // R3: taken branch deferred by back-pressure, then released
    branch(0, 1, 0, 0, 32'h0000_2000);
    idle(0);
    idle(1);
    idle(1);
    // R4: not-taken branch
    branch(1, 0, 0, 0, 32'h0000_9000);
    // R5 + R11: immediate link jump, non-register target with low bits set
    branch(1, 1, 0, 1, 32'h0000_3003);
    idle(1);
    // R6: register jump to misaligned target
    branch(1, 1, 1, 0, 32'h0000_4002);
    idle(0);
    step(0, 0, 0, 0, 0, 32'h0, 32'h0, 1, m_pc, 0);
    idle(1); idle(1);
    // R9: exception in delay slot of a not-taken branch, then restart (R10)
    branch(1, 0, 0, 0, 32'h0000_5000);
    step(1, 0, 0, 0, 0, 32'h0, 32'h0, 1, m_tpc[0] + 32'd4, 0);
    idle(1);
    step(0, 0, 0, 0, 0, 32'h0, 32'h0, 0, 32'h0, 1);
    idle(1);
    // R7: exception wins over eret, branch and link in the same cycle
    step(1, 1, 1, 0, 1, m_pc - 32'd4, 32'h0000_6000, 1, 32'h0000_7770, 1);
    idle(1);
    // R9 boundary: branch pushed out of the history is no longer matched
    bp = m_pc - 32'd4;
    for (int k = 0; k <= DEPTH; k++) branch(1, 0, 0, 0, 32'h0);
    step(1, 0, 0, 0, 0, 32'h0, 32'h0, 1, bp + 32'd4, 0);
    idle(1);
    // R10: restart from plain EPC
    step(1, 0, 0, 0, 0, 32'h0, 32'h0, 0, 32'h0, 1);
    ds_open = 0;
    for (int n = 0; n < 4000; n++) begin
      bit rdy = ($urandom % 10) < 7;
      bit ex = ($urandom % 100) < 6;
      bit er = ($urandom % 100) < 4;
      bit bv = !ds_open && !m_pend && m_valid && (($urandom % 100) < 30);
      bit bt = $urandom % 2;
      bit breg = $urandom % 2;
      bit blnk = ($urandom % 4) == 0;
      logic [31:0] tg = $urandom & 32'h000F_FFFF;
      logic [31:0] xp;
      int j = $urandom % DEPTH;
      if (!breg || ($urandom % 5) != 0) tg = tg & ~32'h3;
      if (m_tv[j] && ($urandom % 2)) xp = m_tpc[j] + 32'd4;
      else xp = $urandom & 32'h000F_FFFC;
      step(rdy, bv, bt, breg, blnk, m_pc - 32'd4, tg, ex, xp, er);
      if (ex || er || (m_valid && rdy)) ds_open = 0;
      else if (bv) ds_open = 1;
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule